// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small 32-bit processor that completes one instruction in every clock: it fetches a word from its instruction store, decodes it, reads two registers, runs the arithmetic unit, touches its data store if needed, writes back and moves the program counter, all before the next rising edge. It handles five instructions: register add, register subtract, word load, word store and branch-if-equal. It holds 32 general registers of 32 bits each.

Both stores are small internal word arrays. While the core is held in reset, a test harness fills them through a single write port, then releases reset and watches the retirement trace. The trace shows the current program counter, the register write of the current instruction and the store of the current instruction.

Top module: `sc_core`

## Requirements
- R1: Register-format words have opcode 0 in bits 31:26, first source in 25:21, second source in 20:16 and destination in 15:11. Function code 32 (bits 5:0) writes rs+rt to rd, and function code 34 writes rs-rt to rd, with 32-bit wraparound.
- R2: Opcode 35 loads the data word at byte address rs + immediate into register rt. The immediate is bits 15:0.
- R3: Opcode 43 stores register rt to byte address rs + immediate and writes no register. A load from that address in the next instruction returns the stored value.
- R4: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the immediate shifted left by two. Otherwise the next PC is PC+4. The instruction writes neither a register nor memory.
- R5: Register 0 always reads as zero. An instruction that names it as destination leaves it unchanged and shows no register write on the trace.
- R6: Every non-branch instruction retires in one clock and advances the PC by exactly 4.
- R7: Reset, active low and asynchronous, sets the PC to 0 and clears every register. While reset is held, no register or data write is reported.
- R8: With the load enable high, the load select chooses the store (0 for instructions, 1 for data), and the word at the given word index takes the load data on the next rising edge.
- R9: The 16-bit immediate is sign-extended, so negative load and store offsets reach addresses below the base register.

Fetch addresses and data addresses outside the stores read as zero. Stores to such addresses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Store preload strobe |
| loadSel | input | 1 | Preload target: 0 instruction store, 1 data store |
| loadAddr | input | MEM_AW | Word index of the preload |
| loadData | input | 32 | Preload word |
| pc | output | 32 | Address of the instruction now executing |
| rfWe | output | 1 | Current instruction writes a register |
| rfWa | output | 5 | Register being written |
| rfWd | output | 32 | Value being written |
| memWe | output | 1 | Current instruction writes the data store |
| memAddr | output | 32 | Byte address computed by the arithmetic unit |
| memWd | output | 32 | Word being stored |

## Verification
The bench goes after a store followed at once by a load of the same word. A core that wrote late or read before the write would return the old contents. It writes to register 0 and then reads it, which catches a core that lets the write land. It uses a negative store offset, where zero-extension would send the store far above the base. Branches are tested not taken, taken forward and taken backward onto themselves. An offset scaled wrongly or measured from the branch's own address would fetch one of the two poisoned words skipped over, or would fail to hold the loop. A second reset followed by an add of two previously written registers must produce zero, which exposes registers that survive reset.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_sel_e;

  typedef struct packed {
    logic       regDst;
    logic       aluSrc;
    logic       memToReg;
    logic       regWrite;
    logic       memRead;
    logic       memWrite;
    logic       branch;
    logic [1:0] aluOp;
    alu_sel_e   aluSel;
  } strobe_t;
endpackage

// File: rtl/core_alu.sv
module core_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  alu_sel_e     sel,
  output logic [W-1:0] result,
  output logic         isZero
);
  always_comb begin
    if (sel == ALU_SUB) result = opA - opB;
    else                result = opA + opB;
  end
  assign isZero = (result == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import sc_core_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [W-1:0]      rdDataA,
  output logic [W-1:0]      rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [W-1:0]      wrData
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  // R5: register 0 stays zero whatever has been written
  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrA == '0) |-> (rdDataA == '0));
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import sc_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output strobe_t    strobe
);
  always_comb begin
    strobe = '0;
    case (opcode)
      OP_REG: begin
        strobe.regDst   = 1'b1;
        strobe.regWrite = 1'b1;
        strobe.aluOp    = 2'b10;
      end
      OP_LOAD: begin
        strobe.aluSrc   = 1'b1;
        strobe.memToReg = 1'b1;
        strobe.regWrite = 1'b1;
        strobe.memRead  = 1'b1;
      end
      OP_STORE: begin
        strobe.aluSrc   = 1'b1;
        strobe.memWrite = 1'b1;
      end
      OP_BEQ: begin
        strobe.branch   = 1'b1;
        strobe.aluOp    = 2'b01;
      end
      default: strobe = '0;
    endcase

    case (strobe.aluOp)
      2'b01:   strobe.aluSel = ALU_SUB;
      2'b10:   strobe.aluSel = (funct == FN_SUB) ? ALU_SUB :
                               (funct == FN_ADD) ? ALU_ADD : ALU_ADD;
      default: strobe.aluSel = ALU_ADD;
    endcase
  end

  p_rtype_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_REG) |-> (strobe.regDst && strobe.regWrite && !strobe.aluSrc
                            && !strobe.memToReg && strobe.aluOp == 2'b10));
  p_load_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_LOAD) |-> (!strobe.regDst && strobe.aluSrc && strobe.memToReg
                             && strobe.memRead && strobe.aluSel == ALU_ADD));
  p_store_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.memWrite |-> (!strobe.regWrite && strobe.aluSrc && strobe.aluSel == ALU_ADD));
  p_beq_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.branch |-> (!strobe.regWrite && !strobe.memWrite && strobe.aluSel == ALU_SUB));
endmodule

// File: rtl/core_dpath.sv
module core_dpath
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]   loadData,
  input  strobe_t           strobe,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   pc,
  output logic              rfWe,
  output logic [REG_AW-1:0] rfWa,
  output logic [XLEN-1:0]   rfWd,
  output logic              memWe,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWd
);
  localparam int WORDS = 2 ** MEM_AW;
  localparam int HI    = MEM_AW + 2;

  logic [XLEN-1:0] imem [WORDS];
  logic [XLEN-1:0] dmem [WORDS];

  logic [XLEN-1:0] instr, immExt, pcPlus4, pcNext;
  logic [XLEN-1:0] rsData, rtData, aluB, aluY, readWord;
  logic            aluZero, fetchOk, dataOk;
  logic [REG_AW-1:0] rsAddr, rtAddr, rdAddr;

  // fetch
  assign fetchOk = (pc[XLEN-1:HI] == '0) && (pc[1:0] == 2'b00);
  assign instr   = fetchOk ? imem[pc[HI-1:2]] : '0;

  // field split
  assign opcode = instr[31:26];
  assign rsAddr = instr[25:21];
  assign rtAddr = instr[20:16];
  assign rdAddr = instr[15:11];
  assign funct  = instr[5:0];
  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};

  core_regfile #(.W(XLEN), .NREG(2 ** REG_AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdAddrA (rsAddr),
    .rdAddrB (rtAddr),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .wrEn    (rfWe),
    .wrAddr  (rfWa),
    .wrData  (rfWd)
  );

  assign aluB = strobe.aluSrc ? immExt : rtData;

  core_alu #(.W(XLEN)) u_alu (
    .opA    (rsData),
    .opB    (aluB),
    .sel    (strobe.aluSel),
    .result (aluY),
    .isZero (aluZero)
  );

  // data access
  assign dataOk   = (aluY[XLEN-1:HI] == '0) && (aluY[1:0] == 2'b00);
  assign readWord = (strobe.memRead && dataOk) ? dmem[aluY[HI-1:2]] : '0;

  assign rfWa  = strobe.regDst ? rdAddr : rtAddr;
  assign rfWd  = strobe.memToReg ? readWord : aluY;
  assign rfWe  = rst_n && strobe.regWrite && (rfWa != '0);
  assign memWe = rst_n && strobe.memWrite && dataOk;
  assign memAddr = aluY;
  assign memWd   = rtData;

  always_ff @(posedge clk) begin
    if (loadEn && !loadSel) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadSel) dmem[loadAddr] <= loadData;
    else if (memWe)        dmem[aluY[HI-1:2]] <= rtData;
  end

  // next PC
  assign pcPlus4 = pc + XLEN'(4);
  assign pcNext  = (strobe.branch && aluZero) ? pcPlus4 + (immExt << 2) : pcPlus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pcNext;
  end

  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.branch |=> (pc == $past(pc) + XLEN'(4)));
  p_branch_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.branch && rsData == rtData) |=> (pc == $past(pc) + XLEN'(4) + ($past(immExt) << 2)));
  p_branch_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.branch && rsData != rtData) |=> (pc == $past(pc) + XLEN'(4)));
  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n |-> (!rfWe && !memWe && pc == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [31:0]       loadData,
  output logic [31:0]       pc,
  output logic              rfWe,
  output logic [4:0]        rfWa,
  output logic [31:0]       rfWd,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWd
);
  strobe_t    strobe;
  logic [5:0] opcode, funct;

  core_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .funct  (funct),
    .strobe (strobe)
  );

  core_dpath #(.MEM_AW(MEM_AW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadEn   (loadEn),
    .loadSel  (loadSel),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .strobe   (strobe),
    .opcode   (opcode),
    .funct    (funct),
    .pc       (pc),
    .rfWe     (rfWe),
    .rfWa     (rfWa),
    .rfWd     (rfWd),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWd    (memWd)
  );
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n, loadEn, loadSel;
  logic [AW-1:0] loadAddr;
  logic [31:0]   loadData, pc, rfWd, memAddr, memWd;
  logic          rfWe, memWe;
  logic [4:0]    rfWa;

  always #5 clk = ~clk;

  sc_core #(.MEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .pc(pc), .rfWe(rfWe),
    .rfWa(rfWa), .rfWd(rfWd), .memWe(memWe), .memAddr(memAddr), .memWd(memWd)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] maddr;
    logic [31:0] mdata;
    logic [7:0]  req;
  } step_t;

  // expected retirement trace of the program loaded below
  localparam step_t STEPS [15] = '{
    '{32'd0,  1'b1, 5'd1, 32'd5,        1'b0, 32'd0,  32'd0,        8'd2}, // R2 lw r1
    '{32'd4,  1'b1, 5'd2, 32'd7,        1'b0, 32'd0,  32'd0,        8'd6}, // R6 lw r2, pc+4
    '{32'd8,  1'b1, 5'd3, 32'd12,       1'b0, 32'd0,  32'd0,        8'd1}, // R1 add
    '{32'd12, 1'b1, 5'd4, 32'hFFFFFFFE, 1'b0, 32'd0,  32'd0,        8'd1}, // R1 sub wraps
    '{32'd16, 1'b0, 5'd0, 32'd0,        1'b1, 32'd12, 32'd12,       8'd3}, // R3 sw
    '{32'd20, 1'b1, 5'd5, 32'd12,       1'b0, 32'd0,  32'd0,        8'd3}, // R3 load after store
    '{32'd24, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd5}, // R5 write r0
    '{32'd28, 1'b1, 5'd6, 32'd5,        1'b0, 32'd0,  32'd0,        8'd5}, // R5 r0 still zero
    '{32'd32, 1'b0, 5'd0, 32'd0,        1'b1, 32'd8,  32'hFFFFFFFE, 8'd9}, // R9 negative offset
    '{32'd36, 1'b1, 5'd7, 32'hFFFFFFFE, 1'b0, 32'd0,  32'd0,        8'd9}, // R9 reload
    '{32'd40, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd4}, // R4 not taken
    '{32'd44, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd4}, // R4 taken fwd
    '{32'd56, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd4}, // R4 target
    '{32'd56, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd4}, // R4 backward self
    '{32'd56, 1'b0, 5'd0, 32'd0,        1'b0, 32'd0,  32'd0,        8'd4}  // R4
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] encI(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(input bit sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadAddr = AW'(idx); loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; loadEn = 1'b0; loadSel = 1'b0; loadAddr = '0; loadData = '0;
    repeat (2) @(negedge clk);
    #1;
    check(pc == 32'd0, "R7 reset pc", pc, 32'd0);
    check(!memWe && !rfWe, "R7 quiet in reset", {30'd0, memWe, rfWe}, 32'd0);

    // program (R8 preload of both stores)
    preload(0, 0,  encI(35, 0, 1, 16'd0));
    preload(0, 1,  encI(35, 0, 2, 16'd4));
    preload(0, 2,  encR(1, 2, 3, 32));
    preload(0, 3,  encR(1, 2, 4, 34));
    preload(0, 4,  encI(43, 0, 3, 16'd12));
    preload(0, 5,  encI(35, 0, 5, 16'd12));
    preload(0, 6,  encR(1, 2, 0, 32));
    preload(0, 7,  encR(0, 1, 6, 32));
    preload(0, 8,  encI(43, 3, 4, 16'hFFFC));
    preload(0, 9,  encI(35, 0, 7, 16'd8));
    preload(0, 10, encI(4, 1, 2, 16'd5));
    preload(0, 11, encI(4, 3, 5, 16'd2));
    preload(0, 12, encR(1, 1, 8, 32));
    preload(0, 13, encR(1, 1, 8, 32));
    preload(0, 14, encI(4, 0, 0, 16'hFFFF));
    preload(1, 0, 32'd5);
    preload(1, 1, 32'd7);
    preload(1, 2, 32'hDEADBEEF);
    preload(1, 3, 32'h0BADF00D);

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 15; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", STEPS[i].req, i);
      check(pc == STEPS[i].pc, {tag, " pc"}, pc, STEPS[i].pc);
      check(rfWe == STEPS[i].we, {tag, " rfWe"}, 32'(rfWe), 32'(STEPS[i].we));
      if (STEPS[i].we) begin
        check(rfWa == STEPS[i].wa, {tag, " rfWa"}, 32'(rfWa), 32'(STEPS[i].wa));
        check(rfWd == STEPS[i].wd, {tag, " rfWd"}, rfWd, STEPS[i].wd);
      end
      check(memWe == STEPS[i].mwe, {tag, " memWe"}, 32'(memWe), 32'(STEPS[i].mwe));
      if (STEPS[i].mwe) begin
        check(memAddr == STEPS[i].maddr, {tag, " memAddr"}, memAddr, STEPS[i].maddr);
        check(memWd == STEPS[i].mdata, {tag, " memWd"}, memWd, STEPS[i].mdata);
      end
      @(negedge clk);
      #1;
    end

    // R7: reset mid-run clears pc at once and wipes registers
    rst_n = 1'b0;
    #1;
    check(pc == 32'd0, "R7 async reset pc", pc, 32'd0);
    preload(0, 0, encR(3, 4, 10, 32));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rfWe && rfWa == 5'd10, "R7 add after reset dest", 32'(rfWa), 32'd10);
    check(rfWd == 32'd0, "R7 registers cleared", rfWd, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule